// File: doc/BRIEF.md
# SDRAM Burst-Read Command Sequencer

This block is the read side of an SDRAM controller. It takes one internal read request, made up of an access size and a byte address, and turns it into SDRAM commands on a 16-bit or 32-bit external data bus. The SDRAM is always run with a burst length of one. A wide access therefore becomes a row activate, an optional run of RAS-to-CAS wait cycles, and then one single-beat read per bus word. The final read of the run carries auto-precharge.

Read data comes back a fixed two clocks after each read command. The block packs it little-endian into a 128-bit result and pulses a done flag. After the auto-precharge read, the block keeps its request input closed to the same bank for a programmable number of precharge-wait cycles. A request to any other bank may start as soon as the sequencer is idle.

The request side is a valid/ready handshake. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_size`, `req_addr`, `req_bus32`, `req_trcd` and `req_trp` must be held steady while `req_valid` is high and `req_ready` is low. They are sampled only at the accepting edge. The result side is a one-cycle `rd_done` pulse with no back-pressure. `rd_data` holds its value until the next request is accepted.

Top module: `sdram_burst_rd`

## Requirements
- R1: `req_ready` is high only while no transfer is in progress and the addressed bank is not in a precharge wait. The bank is `req_addr[10:9]`. On the cycle after an accepting edge, the command pins carry the activate code {cs_n,ras_n,cas_n,we_n}=0011. In that cycle `sd_addr` carries the row `req_addr[22:11]` and `sd_ba` carries the bank.
- R2: The number of read beats depends on the size code and the bus width. Size codes are 0 for a byte, 1 for a halfword, 2 for a word and 3 for a 16-byte line. On the 32-bit bus (`req_bus32`=1) the counts are 1, 1, 1 and 4. On the 16-bit bus they are 1, 1, 2 and 8.
- R3: Exactly `req_trcd` cycles (0 to 3) of NOP (0111) separate the activate from the first read command.
- R4: Read commands (0101) go out on consecutive cycles, one per beat. `sd_ba` stays fixed across them. `sd_addr[8:0]` starts at `req_addr[8:0]` with its low bits cleared to the access alignment: none for a byte, 1 bit for a halfword, 2 bits for a word and 4 bits for a line. Each following beat adds 2 on the 16-bit bus or 4 on the 32-bit bus, modulo 512.
- R5: `sd_addr[10]` (auto-precharge) is high on the last read command of a transfer and low on every earlier one.
- R6: The data for each read command is sampled from `sd_dq_in` at the end of the second cycle after that command. Beat k is stored at `rd_data[32k+:32]` on the 32-bit bus, or at `rd_data[16k+:16]` from `sd_dq_in[15:0]` on the 16-bit bus. All other bits are zero.
- R7: `rd_done` is high for exactly one cycle: the cycle after the last data sample. `rd_data` is complete in that cycle and keeps its value afterwards until the next acceptance.
- R8: For the bank just read, `req_ready` stays low in the done cycle and rises `req_trp`+1 cycles after it.
- R9: In the done cycle, `req_ready` is high for a request to a different bank, and such a request is accepted at that edge.
- R10: Every cycle that carries no activate or read carries NOP (0111).
- R11: After reset the pins show NOP, `req_ready` is high, `rd_done` is low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 line) |
| req_addr | input | 23 | Byte address {row, bank, column} |
| req_bus32 | input | 1 | 1 selects the 32-bit data bus, 0 the 16-bit bus |
| req_trcd | input | 2 | Extra NOP cycles between activate and first read |
| req_trp | input | 2 | Precharge-wait setting; bank held trp+1 cycles after done |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Row or column address; bit 10 selects auto-precharge |
| sd_ba | output | 2 | Bank select |
| sd_dq_in | input | 32 | Read data from the SDRAM |
| rd_data | output | 128 | Assembled read result |
| rd_done | output | 1 | One-cycle pulse, result complete |

## Verification
The hardest situation to reach is the overlap of one bank's precharge wait with a new request to another bank in the very cycle the previous transfer completes. Reaching it needs a request held valid across the done edge, with its address already switched to a second bank. A directed sequence sets this up right after an acceptance and checks that the second activate follows the done cycle with no gap. Around that case, a full sweep over size, bus width, RAS-to-CAS and precharge settings drives reply data two cycles after each read. At each done pulse it swaps the address bank to probe the ready gating for both the same bank and another bank.

// File: rtl/sdrb_pkg.sv
package sdrb_pkg;

  typedef enum logic [3:0] {
    CMD_ACTV = 4'b0011,
    CMD_READ = 4'b0101,
    CMD_NOP  = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_RCD,
    ST_RD,
    ST_DRAIN
  } seq_st_e;

  // beats needed for one access: size 0 byte, 1 half, 2 word, 3 line
  function automatic logic [3:0] beat_count(input logic [1:0] sz, input logic wide);
    logic [3:0] n;
    case (sz)
      2'd0, 2'd1: n = 4'd1;
      2'd2:       n = wide ? 4'd1 : 4'd2;
      default:    n = wide ? 4'd4 : 4'd8;
    endcase
    return n;
  endfunction

  // low column bits cleared to align the first beat
  function automatic logic [3:0] align_mask(input logic [1:0] sz);
    logic [3:0] m;
    case (sz)
      2'd0:    m = 4'b0000;
      2'd1:    m = 4'b0001;
      2'd2:    m = 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sdrb_seq.sv
module sdrb_seq
  import sdrb_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BA_W   = 2,
  parameter int ROW_W  = 12,
  parameter int AP_BIT = 10,
  parameter int ADDR_W = COL_W + BA_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_bus32,
  input  logic [1:0]        req_trcd,
  input  logic [1:0]        req_trp,
  input  logic              last_captured,
  output logic              idle,
  output sd_cmd_e           cmd,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              issue,
  output logic              issue_last,
  output logic              wide,
  output logic [1:0]        trp
);

  seq_st_e          st;
  logic [1:0]       wcnt;
  logic [3:0]       beat, nbeat;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             last_beat;

  assign last_beat = (beat == nbeat - 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; wcnt <= '0; beat <= '0; nbeat <= 4'd1;
      col <= '0; row <= '0; sd_ba <= '0; wide <= 1'b0; trp <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          row   <= req_addr[COL_W+BA_W +: ROW_W];
          sd_ba <= req_addr[COL_W +: BA_W];
          col   <= req_addr[COL_W-1:0] & ~COL_W'(align_mask(req_size));
          nbeat <= beat_count(req_size, req_bus32);
          wide  <= req_bus32;
          wcnt  <= req_trcd;
          trp   <= req_trp;
          beat  <= '0;
          st    <= ST_ACT;
        end
        ST_ACT:  st <= (wcnt == 2'd0) ? ST_RD : ST_RCD;
        ST_RCD: begin
          wcnt <= wcnt - 2'd1;
          if (wcnt == 2'd1) st <= ST_RD;
        end
        ST_RD: begin
          beat <= beat + 4'd1;
          col  <= col + (wide ? COL_W'(4) : COL_W'(2));
          if (last_beat) st <= ST_DRAIN;
        end
        ST_DRAIN: if (last_captured) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd     = CMD_NOP;
    sd_addr = '0;
    if (st == ST_ACT) begin
      cmd     = CMD_ACTV;
      sd_addr = row;
    end else if (st == ST_RD) begin
      cmd             = CMD_READ;
      sd_addr         = ROW_W'(col);
      sd_addr[AP_BIT] = last_beat;
    end
  end

  assign idle       = (st == ST_IDLE);
  assign issue      = (st == ST_RD);
  assign issue_last = issue && last_beat;

endmodule

// File: rtl/sdrb_capture.sv
module sdrb_capture #(
  parameter int CAS_LAT = 2,
  parameter int DQ_W    = 32,
  parameter int LINE_W  = 128,
  parameter int HALF_W  = DQ_W / 2,
  parameter int IDX_W   = $clog2(LINE_W / HALF_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              issue,
  input  logic              issue_last,
  input  logic              wide,
  input  logic [DQ_W-1:0]   dq,
  output logic              last_captured,
  output logic [LINE_W-1:0] rd_data,
  output logic              rd_done
);

  logic [CAS_LAT-1:0] vld_p, last_p;
  logic [IDX_W-1:0]   idx;
  logic               fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_p <= '0; last_p <= '0;
    end else begin
      vld_p[0]  <= issue;
      last_p[0] <= issue_last;
      for (int i = 1; i < CAS_LAT; i++) begin
        vld_p[i]  <= vld_p[i-1];
        last_p[i] <= last_p[i-1];
      end
    end
  end

  assign fire          = vld_p[CAS_LAT-1];
  assign last_captured = fire && last_p[CAS_LAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0; idx <= '0; rd_done <= 1'b0;
    end else begin
      rd_done <= last_captured;
      if (clear) begin
        rd_data <= '0;
        idx     <= '0;
      end else if (fire) begin
        if (wide) rd_data[idx[IDX_W-2:0]*DQ_W +: DQ_W] <= dq;
        else      rd_data[idx*HALF_W +: HALF_W]         <= dq[HALF_W-1:0];
        idx <= idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdrb_bank_guard.sv
module sdrb_bank_guard #(
  parameter int BA_W    = 2,
  parameter int CAS_LAT = 2,
  parameter int NBANK   = 1 << BA_W,
  parameter int TW      = $clog2(CAS_LAT + 6)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BA_W-1:0]  load_bank,
  input  logic [1:0]       trp,
  output logic [NBANK-1:0] busy
);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [TW-1:0] tmr;
    always_ff @(posedge clk) begin
      if (!rst_n)                                tmr <= '0;
      else if (load && load_bank == BA_W'(g))    tmr <= TW'(CAS_LAT + 1) + TW'(trp);
      else if (tmr != '0)                        tmr <= tmr - 1'b1;
    end
    assign busy[g] = (tmr != '0);
  end

endmodule

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd
  import sdrb_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int BA_W    = 2,
  parameter int ROW_W   = 12,
  parameter int CAS_LAT = 2,
  parameter int DQ_W    = 32,
  parameter int LINE_W  = 128,
  parameter int ADDR_W  = COL_W + BA_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_bus32,
  input  logic [1:0]        req_trcd,
  input  logic [1:0]        req_trp,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  input  logic [DQ_W-1:0]   sd_dq_in,
  output logic [LINE_W-1:0] rd_data,
  output logic              rd_done
);

  localparam int NBANK = 1 << BA_W;

  sd_cmd_e          cmd;
  logic             idle, accept, issue, issue_last, wide, last_captured;
  logic [1:0]       trp;
  logic [NBANK-1:0] bank_busy;

  assign req_ready = idle && !bank_busy[req_addr[COL_W +: BA_W]];
  assign accept    = req_valid && req_ready;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  sdrb_seq #(.COL_W(COL_W), .BA_W(BA_W), .ROW_W(ROW_W)) u_seq (
    .clk, .rst_n, .accept, .req_size, .req_addr, .req_bus32, .req_trcd,
    .req_trp, .last_captured, .idle, .cmd, .sd_addr, .sd_ba, .issue,
    .issue_last, .wide, .trp
  );

  sdrb_capture #(.CAS_LAT(CAS_LAT), .DQ_W(DQ_W), .LINE_W(LINE_W)) u_cap (
    .clk, .rst_n, .clear(accept), .issue, .issue_last, .wide,
    .dq(sd_dq_in), .last_captured, .rd_data, .rd_done
  );

  sdrb_bank_guard #(.BA_W(BA_W), .CAS_LAT(CAS_LAT)) u_guard (
    .clk, .rst_n, .load(issue_last), .load_bank(sd_ba), .trp,
    .busy(bank_busy)
  );

endmodule

// File: rtl/sdrb_chk.sv
module sdrb_chk #(
  parameter int BA_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            sd_cs_n,
  input logic            sd_ras_n,
  input logic            sd_cas_n,
  input logic            sd_we_n,
  input logic [BA_W-1:0] sd_ba,
  input logic            rd_done
);

  logic [3:0] pins;
  assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // R1
  accept_to_actv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (pins == 4'b0011));

  // R1
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins != 4'b0111) |-> !req_ready);

  // R10
  cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0011) || (pins == 4'b0101) || (pins == 4'b0111));

  // R4
  bank_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0101) |-> $stable(sd_ba));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

endmodule

bind sdram_burst_rd sdrb_chk #(.BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
  .sd_we_n(sd_we_n), .sd_ba(sd_ba), .rd_done(rd_done)
);

// File: tb/sdram_burst_rd_test.sv
module sdram_burst_rd_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_size = '0;
  logic [22:0]  req_addr = '0;
  logic         req_bus32 = 1'b0;
  logic [1:0]   req_trcd = '0;
  logic [1:0]   req_trp = '0;
  logic         sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [11:0]  sd_addr;
  logic [1:0]   sd_ba;
  logic [31:0]  sd_dq_in = '1;
  logic [127:0] rd_data;
  logic         rd_done;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sdram_burst_rd uut (
    .clk, .rst_n, .req_valid, .req_ready, .req_size, .req_addr, .req_bus32,
    .req_trcd, .req_trp, .sd_cs_n, .sd_ras_n, .sd_cas_n, .sd_we_n, .sd_addr,
    .sd_ba, .sd_dq_in, .rd_data, .rd_done
  );

  function automatic logic [3:0] pins();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int beats(input int sz, input bit b32);
    if (sz < 2) return 1;
    if (sz == 2) return b32 ? 1 : 2;
    return b32 ? 4 : 8;
  endfunction

  task automatic run_txn(input int sz, input bit b32, input int trcd,
                         input int trp, input logic [22:0] addr, input logic [7:0] tag);
    int n, kc0, kd, step;
    logic [8:0]   base;
    logic [127:0] exp_data;
    logic [31:0]  pat;
    logic [11:0]  ea;
    n = beats(sz, b32);
    kc0 = 2 + trcd;
    kd = 4 + trcd + n;
    step = b32 ? 4 : 2;
    base = addr[8:0] & ~9'((sz == 0) ? 0 : (sz == 1) ? 1 : (sz == 2) ? 3 : 15);
    exp_data = '0;
    @(negedge clk);
    req_size = 2'(sz); req_bus32 = b32; req_trcd = 2'(trcd); req_trp = 2'(trp);
    req_addr = addr; req_valid = 1'b1;
    #1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int k = 1; k <= kd; k++) begin
      @(negedge clk);
      if (k == 1)
        chk(pins() == 4'b0011 && sd_addr == addr[22:11] && sd_ba == addr[10:9],
            "R1 activate", {pins(), sd_ba, sd_addr}, {4'b0011, addr[10:9], addr[22:11]});
      else if (k < kc0)
        chk(pins() == 4'b0111, "R3 rcd nop", pins(), 4'b0111);
      else if (k < kc0 + n) begin
        ea = 12'(9'(base + 9'((k - kc0) * step)));
        ea[10] = (k - kc0 == n - 1);
        chk(pins() == 4'b0101 && sd_addr == ea && sd_ba == addr[10:9],
            "R4/R5 read beat", {pins(), sd_ba, sd_addr}, {4'b0101, addr[10:9], ea});
      end else
        chk(pins() == 4'b0111, "R10 idle nop", pins(), 4'b0111);
      if (k < kd)
        chk(!rd_done, "R7 early done", rd_done, 0);
      else
        chk(rd_done && rd_data == exp_data, "R2/R6 result", rd_data, exp_data);
      if (k >= kc0 + 2 && k < kc0 + 2 + n) begin
        pat = {tag, 8'(k - kc0 - 2), 16'(tag * 97 + k * 13)};
        sd_dq_in = pat;
        if (b32) exp_data[(k - kc0 - 2) * 32 +: 32] = pat;
        else     exp_data[(k - kc0 - 2) * 16 +: 16] = pat[15:0];
      end else
        sd_dq_in = 32'hFFFF_FFFF;
    end
    // done cycle: same bank held, other bank free
    chk(!req_ready, "R8 same bank held at done", req_ready, 0);
    req_addr = addr ^ 23'h200;
    #1 chk(req_ready, "R9 other bank free at done", req_ready, 1);
    req_addr = addr;
    #1;
    for (int j = 1; j <= trp + 1; j++) begin
      @(negedge clk);
      chk(req_ready == (j == trp + 1), "R8 precharge wait", req_ready, (j == trp + 1));
      if (j == 1)
        chk(!rd_done && rd_data == exp_data, "R7 hold after done", {rd_done, rd_data},
            {1'b0, exp_data});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pins() == 4'b0111 && req_ready && !rd_done && rd_data == '0,
        "R11 reset state", {pins(), req_ready, rd_done}, {4'b0111, 1'b1, 1'b0});

    i = 0;
    for (int sz = 0; sz < 4; sz++)
      for (int b = 0; b < 2; b++)
        for (int rc = 0; rc < 4; rc++)
          for (int tp = 0; tp < 4; tp++) begin
            run_txn(sz, b[0], rc, tp,
                    {12'(i * 53 + 7), 2'(i), 9'(i * 29 + 5)}, 8'(i + 1));
            i++;
          end

    // R9 directed: other-bank request held across the done edge
    @(negedge clk);
    req_size = 2'd0; req_bus32 = 1'b1; req_trcd = 2'd0; req_trp = 2'd3;
    req_addr = {12'h0A5, 2'd0, 9'h010}; req_valid = 1'b1;
    @(posedge clk);
    #1 req_addr = {12'h05A, 2'd1, 9'h020};
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk(!req_ready, "R1 busy blocks ready", req_ready, 0);
    end
    @(negedge clk);
    chk(rd_done && req_ready, "R9 accept in done cycle", {rd_done, req_ready}, 2'b11);
    @(negedge clk);
    chk(pins() == 4'b0011 && sd_ba == 2'd1 && sd_addr == 12'h05A,
        "R9 second activate", {pins(), sd_ba, sd_addr}, {4'b0011, 2'd1, 12'h05A});
    req_valid = 1'b0;
    repeat (12) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule